// File: doc/BRIEF.md
# Selectable Event Statistics Counter

This block is a 32-bit event counter that measures one of several internal activity signals. A three-bit selector chooses the source from four event lanes: instruction cache hit, processor memory cycle, an instruction status bit, and program counter in the high code region. The chosen signal can be inverted before it is counted. It can then be counted in one of two ways: once per rising edge, or once for every clock cycle in which it is high.

The selector, the inversion bit and the mode bit come from a control register outside the block. That register is cleared by reset, so a reset configuration selects the cache hit lane, no inversion and edge counting. Software can overwrite the count at any time through a write strobe and a data word. The count is always visible on the output.

Top module: `evt_stat_counter`

## Requirements
- R1: Reset clears the count to 0 and clears the edge history, so a conditioned signal that is already high when reset is released counts as one rising edge in edge mode.
- R2: Selector code 000 picks event lane bit 0 (instruction cache hit), 001 picks bit 1 (memory cycle), 010 picks bit 2 (instruction status), and 100 picks bit 3 (program counter in high code). Lanes that are not selected have no effect.
- R3: Selector codes 011, 101, 110 and 111 make the conditioned signal a constant 0. Whatever the inversion bit, the mode bit and the event lanes, the count does not advance.
- R4: When the inversion bit is 1, the selected lane is inverted before it is counted. This applies in both modes.
- R5: With the mode bit at 0 (edge mode), the count rises by one in each cycle where the conditioned signal is 1 and was 0 in the previous cycle. A signal held high adds nothing more.
- R6: With the mode bit at 1 (duration mode), the count rises by one in every cycle where the conditioned signal is 1.
- R7: A write strobe loads the write data into the count. A write takes priority over an increment in the same cycle.
- R8: The count wraps from all ones to zero.
- R9: The edge history is updated in both modes. After a switch from duration mode to edge mode while the signal is high, nothing is counted until the signal falls and rises again.
- R10: A qualifying cycle or a write is seen on the count output right after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_lanes_i | input | 4 | Event lanes: bit0 cache hit, bit1 memory cycle, bit2 instruction status, bit3 high code PC |
| cfg_src_sel_i | input | 3 | Source selector code |
| cfg_invert_i | input | 1 | 1 inverts the selected source |
| cfg_duration_i | input | 1 | 0 counts rising edges, 1 counts high cycles |
| cnt_wr_en_i | input | 1 | Count write strobe |
| cnt_wr_data_i | input | 32 | Value loaded into the count |
| count_o | output | 32 | Current count |

## Verification
The hardest situation to reach from the ports is a rising edge that is missed or counted twice when the mode changes. The history register is hidden, and only the sequence of earlier conditioned values sets it. The stimulus first holds an inverted lane high in duration mode. It then switches to edge mode with the signal still high, so any stale history shows up as an extra count. After that it drops and raises the signal to prove that a fresh edge still counts. Separately, a reset is applied while the inverted signal is high, to show that the cleared history turns the first cycle after reset into a counted edge.

// File: rtl/evtc_pkg.sv
package evtc_pkg;

    localparam int NUM_EV = 4;
    localparam int SEL_W  = 3;
    localparam int LANE_W = $clog2(NUM_EV);

    typedef enum logic [SEL_W-1:0] {
        SRC_CACHE_HIT = 3'b000,
        SRC_MEM_CYCLE = 3'b001,
        SRC_INSN_STAT = 3'b010,
        SRC_RSVD_3    = 3'b011,
        SRC_PC_HIGH   = 3'b100,
        SRC_RSVD_5    = 3'b101,
        SRC_RSVD_6    = 3'b110,
        SRC_RSVD_7    = 3'b111
    } src_code_e;

    typedef struct packed {
        logic              valid;
        logic [LANE_W-1:0] lane;
    } lane_pick_t;

    // Maps a selector code to an event lane; reserved codes are invalid.
    function automatic lane_pick_t decode_src(input logic [SEL_W-1:0] code);
        lane_pick_t p;
        p = '0;
        case (src_code_e'(code))
            SRC_CACHE_HIT: begin p.valid = 1'b1; p.lane = LANE_W'(0); end
            SRC_MEM_CYCLE: begin p.valid = 1'b1; p.lane = LANE_W'(1); end
            SRC_INSN_STAT: begin p.valid = 1'b1; p.lane = LANE_W'(2); end
            SRC_PC_HIGH:   begin p.valid = 1'b1; p.lane = LANE_W'(3); end
            default:       p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/evtc_src_cond.sv
module evtc_src_cond
    import evtc_pkg::*;
#(
    parameter int N_LANES = NUM_EV
) (
    input  logic [N_LANES-1:0] ev_lanes_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               invert_i,
    output logic               cond_o
);

    lane_pick_t         pick;
    logic [N_LANES-1:0] lane_hit;

    assign pick = decode_src(sel_i);

    genvar g;
    generate
        for (g = 0; g < N_LANES; g++) begin : g_lane
            assign lane_hit[g] = ev_lanes_i[g] & (int'(pick.lane) == g);
        end
    endgenerate

    always_comb begin
        if (pick.valid) begin
            cond_o = (|lane_hit) ^ invert_i;
        end else begin
            cond_o = 1'b0;
        end
    end

    // R3
    always_comb begin
        reserved_quiet_chk: assert (pick.valid || !cond_o);
    end

endmodule

// File: rtl/evtc_trigger.sv
module evtc_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    input  logic duration_i,
    output logic inc_o
);

    typedef struct packed {
        logic prev;
    } trig_state_t;

    trig_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cond_i;
        if (duration_i) begin
            inc_o = cond_i;
        end else begin
            inc_o = cond_i & ~st_q.prev;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    inc_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_o |-> cond_i);

    // R5
    edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_i ##1 (cond_i && !duration_i) |-> !inc_o);

    // R6
    duration_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i && duration_i) |-> inc_o);

endmodule

// File: rtl/evtc_count_reg.sv
module evtc_count_reg #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.count = wr_data_i;
        end else if (inc_i) begin
            st_d.count = st_q.count + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

    // R7
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (count_o == $past(wr_data_i)));

    // R8
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && inc_i) |=> (count_o == $past(count_o) + ONE));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !inc_i) |=> $stable(count_o));

endmodule

// File: rtl/evt_stat_counter.sv
module evt_stat_counter
    import evtc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_lanes_i,
    input  logic [SEL_W-1:0]  cfg_src_sel_i,
    input  logic              cfg_invert_i,
    input  logic              cfg_duration_i,
    input  logic              cnt_wr_en_i,
    input  logic [CNT_W-1:0]  cnt_wr_data_i,
    output logic [CNT_W-1:0]  count_o
);

    logic cond;
    logic inc;

    evtc_src_cond #(
        .N_LANES (NUM_EV)
    ) u_src (
        .ev_lanes_i (ev_lanes_i),
        .sel_i      (cfg_src_sel_i),
        .invert_i   (cfg_invert_i),
        .cond_o     (cond)
    );

    evtc_trigger u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond_i     (cond),
        .duration_i (cfg_duration_i),
        .inc_o      (inc)
    );

    evtc_count_reg #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cnt_wr_en_i),
        .wr_data_i (cnt_wr_data_i),
        .inc_i     (inc),
        .count_o   (count_o)
    );

    // R3
    reserved_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr_en_i && !decode_src(cfg_src_sel_i).valid) |=> $stable(count_o));

endmodule

// File: tb/tb_evt_stat_counter.sv
module tb_evt_stat_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ev = '0;
    logic [2:0]  sel = '0;
    logic        inv = 1'b0;
    logic        dur = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evt_stat_counter dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_lanes_i     (ev),
        .cfg_src_sel_i  (sel),
        .cfg_invert_i   (inv),
        .cfg_duration_i (dur),
        .cnt_wr_en_i    (wr_en),
        .cnt_wr_data_i  (wr_data),
        .count_o        (count)
    );

    // row: {req[3:0], sel[2:0], inv, dur, ev[3:0], expected count[31:0]}
    localparam int ROWS = 22;
    localparam logic [44:0] VEC [ROWS] = '{
        {4'd6, 3'b000, 1'b0, 1'b1, 4'b0001, 32'd1},
        {4'd6, 3'b000, 1'b0, 1'b1, 4'b0001, 32'd2},
        {4'd6, 3'b000, 1'b0, 1'b1, 4'b0000, 32'd2},
        {4'd2, 3'b001, 1'b0, 1'b1, 4'b0010, 32'd3},
        {4'd2, 3'b001, 1'b0, 1'b1, 4'b0001, 32'd3},
        {4'd2, 3'b010, 1'b0, 1'b1, 4'b0100, 32'd4},
        {4'd2, 3'b100, 1'b0, 1'b1, 4'b1000, 32'd5},
        {4'd4, 3'b100, 1'b1, 1'b1, 4'b1000, 32'd5},
        {4'd4, 3'b100, 1'b1, 1'b1, 4'b0000, 32'd6},
        {4'd9, 3'b100, 1'b1, 1'b0, 4'b0000, 32'd6},
        {4'd9, 3'b100, 1'b1, 1'b0, 4'b1000, 32'd6},
        {4'd9, 3'b100, 1'b1, 1'b0, 4'b0000, 32'd7},
        {4'd5, 3'b100, 1'b1, 1'b0, 4'b0000, 32'd7},
        {4'd5, 3'b000, 1'b0, 1'b0, 4'b0000, 32'd7},
        {4'd5, 3'b000, 1'b0, 1'b0, 4'b0001, 32'd8},
        {4'd5, 3'b000, 1'b0, 1'b0, 4'b0000, 32'd8},
        {4'd5, 3'b000, 1'b0, 1'b0, 4'b0001, 32'd9},
        {4'd3, 3'b011, 1'b0, 1'b1, 4'b1111, 32'd9},
        {4'd3, 3'b101, 1'b1, 1'b1, 4'b0000, 32'd9},
        {4'd3, 3'b110, 1'b1, 1'b0, 4'b0000, 32'd9},
        {4'd3, 3'b111, 1'b0, 1'b1, 4'b1111, 32'd9},
        {4'd4, 3'b000, 1'b1, 1'b0, 4'b0000, 32'd10}
    };

    function automatic string req_tag(input logic [3:0] r);
        case (r)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: count actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step_and_check(input string req, input logic [31:0] exp);
        @(posedge clk);
        #1;
        check(req, count, exp);
    endtask

    initial begin
        #1ms;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: count is zero after reset with all inputs idle
        step_and_check("R1", 32'd0);

        for (int i = 0; i < ROWS; i++) begin
            @(negedge clk);
            sel = VEC[i][40:38];
            inv = VEC[i][37];
            dur = VEC[i][36];
            ev  = VEC[i][35:32];
            step_and_check(req_tag(VEC[i][44:41]), VEC[i][31:0]);
        end

        // R1: reset while the inverted signal is high, history cleared
        @(negedge clk);
        sel = 3'b000; inv = 1'b1; dur = 1'b0; ev = 4'b0000;
        rst_n = 1'b0;
        step_and_check("R1", 32'd0);
        step_and_check("R1", 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step_and_check("R1", 32'd1);

        // R7: write wins over an increment in the same cycle
        @(negedge clk);
        inv = 1'b0; dur = 1'b1; ev = 4'b0001;
        wr_en = 1'b1; wr_data = 32'h0000_1234;
        step_and_check("R7", 32'h0000_1234);
        @(negedge clk);
        wr_en = 1'b0;
        step_and_check("R7", 32'h0000_1235);

        // R8: wrap from all ones to zero
        @(negedge clk);
        ev = 4'b0000; wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
        step_and_check("R8", 32'hFFFF_FFFF);
        @(negedge clk);
        wr_en = 1'b0; ev = 4'b0001;
        step_and_check("R8", 32'd0);

        // R10: no change before the edge, change right after it
        @(negedge clk);
        #2;
        check("R10", count, 32'd0);
        step_and_check("R10", 32'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule